// File: doc/BRIEF.md
# Codec Link Command and Status Core

This unit is the register-level control core of an audio codec link host controller. Software reaches it through a small word-addressed register port with four registers: link control, link status, codec command and codec reply. The unit drives the link's reset, enable and transfer controls. It tracks a main link state that goes from idle to initialised, then to transfer-ready, then to active. It holds the transfer-mode fields for the three sample streams.

Codec register access is posted. Software writes one command word that carries a read flag, a 7-bit codec register address and 16 bits of write data. The unit raises a slot request and holds it until the link side acknowledges the slot with the codec's reply. The reply's echoed address and data are latched into the reply register, and a ready flag is raised. When the ready interrupt enable is set, that flag drives the interrupt line. Bit 30 of the control word is write-one-to-clear for the flag. Serial framing, sample buffering and DMA lie outside this unit. The link side is modelled as a request/acknowledge handshake.

Top module: `aclink_ctrl_core`

## Requirements
- R1: After synchronous reset, all four registers read 0, `irq` and `slot_req` are 0, and all link and mode outputs are 0.
- R2: The main state is read in status bits [2:0] with 0 = idle, 1 = initialised, 2 = transfer-ready and 3 = active. It is 0 while link-on (control bit 2) is clear, 1 while link-on is set without transfer-enable (control bit 3), and 2 when both are set. It becomes 3 only from state 2, on the clock after `codec_ready_in` is seen. It follows the control bits one clock after they are written.
- R3: Register addresses on `bus_addr` are 0 = control, 1 = status, 2 = command and 3 = reply. A write to the command register while no command is pending posts it on the next clock. `slot_req` rises, `slot_rd` takes bit 23, `slot_addr` takes bits 22:16 and `slot_wdata` takes bits 15:0. Status bit 5 reads 1 while the command is pending.
- R4: A command write made while a command is pending is ignored. The slot outputs and the command register keep the first command.
- R5: When `slot_ack` is high while a command is pending, the pending state ends on that clock. The reply register then reads the acknowledged address in bits 22:16 and the acknowledged data in bits 15:0, and the ready flag (status bit 4) is set.
- R6: `irq` is high exactly when the ready flag is set and the ready interrupt enable (control bit 4) is set. It is updated on the same clock as the flag.
- R7: Writing control with bit 30 set clears the ready flag and `irq` on that clock. Bit 30 always reads 0. If a ready event occurs on the same clock as the clear, the flag stays set.
- R8: Entering the active state sets the ready flag.
- R9: Writing control with bit 0 (cold reset) set clears every control field, the main state, any pending command and the reply register on that clock, and drives `lnk_cold` high. While cold reset is held, command writes are ignored. A later control write with bit 0 clear releases it.
- R10: Control bit 1 drives `lnk_warm`. A control write made while the main state is active leaves `lnk_warm` at 0.
- R11: The three 2-bit transfer-mode fields at control bits [9:8] (PCM in), [11:10] (PCM out) and [13:12] (mic in) are stored independently. They read back in place and drive `pcm_in_mode`, `pcm_out_mode` and `mic_mode`.
- R12: `bus_rdata` is registered and shows the register selected by `bus_addr` as it stood before the clock edge that latches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| lnk_cold | output | 1 | Cold reset to the link |
| lnk_warm | output | 1 | Warm reset to the link |
| lnk_run | output | 1 | Link-on control |
| lnk_xfer | output | 1 | Transfer-data enable |
| codec_ready_in | input | 1 | Codec ready reported by the link |
| slot_req | output | 1 | Command slot pending |
| slot_rd | output | 1 | Pending command is a read |
| slot_addr | output | 7 | Codec register address of pending command |
| slot_wdata | output | 16 | Write data of pending command |
| slot_ack | input | 1 | Slot completed, reply valid |
| slot_rsp_addr | input | 7 | Address echoed by the codec |
| slot_rsp_data | input | 16 | Data returned by the codec |
| pcm_in_mode | output | 2 | PCM-in transfer mode |
| pcm_out_mode | output | 2 | PCM-out transfer mode |
| mic_mode | output | 2 | Mic-in transfer mode |
| irq | output | 1 | Codec-ready interrupt |

## Verification
A wrong main state shows in status bits [2:0] on the next read, one clock after the control write that should have moved it. It also shows as a missing ready interrupt when the active state is entered. A corrupt pending flag shows at once on `slot_req`, or as a second command that takes over the slot fields. A missed acknowledge leaves `irq` low on the clock after `slot_ack`, and the reply register then reads back the wrong address and data. A cold reset that fails to clear state leaves `slot_req`, `irq` or the state field non-zero on the very next cycle.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  // control register bit positions
  localparam int CTL_COLD    = 0;
  localparam int CTL_WARM    = 1;
  localparam int CTL_LINKON  = 2;
  localparam int CTL_XFER    = 3;
  localparam int CTL_RDYIE   = 4;
  localparam int CTL_MODE0   = 8;   // first of the packed mode fields
  localparam int CTL_IRQCLR  = 30;
  // status register bit positions
  localparam int STS_RDY     = 4;
  localparam int STS_BUSY    = 5;
  // command / reply layout
  localparam int CMD_ADDR_LSB = 16;
  localparam int CMD_RDFLAG   = 23;

  typedef enum logic [2:0] {
    MS_IDLE   = 3'd0,
    MS_INIT   = 3'd1,
    MS_READY  = 3'd2,
    MS_ACTIVE = 3'd3
  } mstate_e;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_STAT  = 2'd1,
    REG_CMD   = 2'd2,
    REG_REPLY = 2'd3
  } regsel_e;
endpackage

// File: rtl/aclk_mainstate.sv
module aclk_mainstate
  import aclk_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    clr,
  input  logic    link_on,
  input  logic    xfer_en,
  input  logic    codec_ready,
  output mstate_e state,
  output logic    enter_active
);
  mstate_e nxt;

  always_comb begin
    if (!link_on)                nxt = MS_IDLE;
    else if (!xfer_en)           nxt = MS_INIT;
    else if (state == MS_ACTIVE) nxt = MS_ACTIVE;
    else if (state == MS_READY && codec_ready) nxt = MS_ACTIVE;
    else                         nxt = MS_READY;
  end

  assign enter_active = !clr && (nxt == MS_ACTIVE) && (state != MS_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst || clr) state <= MS_IDLE;
    else            state <= nxt;
  end
endmodule

// File: rtl/aclk_cmdslot.sv
module aclk_cmdslot #(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          post,
  input  logic          post_rd,
  input  logic [AW-1:0] post_addr,
  input  logic [DW-1:0] post_data,
  input  logic          ack,
  input  logic [AW-1:0] rsp_addr,
  input  logic [DW-1:0] rsp_data,
  output logic          pending,
  output logic          cmd_rd,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic [AW-1:0] rep_addr,
  output logic [DW-1:0] rep_data,
  output logic          done
);
  assign done = pending && ack && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pending  <= 1'b0;
      cmd_rd   <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
      rep_addr <= '0;
      rep_data <= '0;
    end else if (pending) begin
      if (ack) begin
        pending  <= 1'b0;
        rep_addr <= rsp_addr;
        rep_data <= rsp_data;
      end
    end else if (post) begin
      pending  <= 1'b1;
      cmd_rd   <= post_rd;
      cmd_addr <= post_addr;
      cmd_data <= post_data;
    end
  end
endmodule

// File: rtl/aclink_ctrl_core.sv
module aclink_ctrl_core
  import aclk_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 16,
  parameter int MW = 2,
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wen,
  input  logic [1:0]    bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  output logic          lnk_cold,
  output logic          lnk_warm,
  output logic          lnk_run,
  output logic          lnk_xfer,
  input  logic          codec_ready_in,
  output logic          slot_req,
  output logic          slot_rd,
  output logic [AW-1:0] slot_addr,
  output logic [DW-1:0] slot_wdata,
  input  logic          slot_ack,
  input  logic [AW-1:0] slot_rsp_addr,
  input  logic [DW-1:0] slot_rsp_data,
  output logic [MW-1:0] pcm_in_mode,
  output logic [MW-1:0] pcm_out_mode,
  output logic [MW-1:0] mic_mode,
  output logic          irq
);
  localparam int NMODE = 3;

  logic cold_q, warm_q, linkon_q, xfer_q, ie_q, flag_q, irq_q;
  logic [MW-1:0] mode_q [NMODE];
  logic ctrl_wr, cmd_wr, cold_set, clr, flag_n, ie_n;
  logic enter_active, cmd_done, pending, cmd_rd;
  logic [AW-1:0] cmd_addr, rep_addr;
  logic [DW-1:0] cmd_data, rep_data;
  logic [BW-1:0] rd_mux;
  mstate_e ms_state;
  logic unused_wbits;

  assign unused_wbits = ^{bus_wdata[BW-1], bus_wdata[29:24]};

  assign ctrl_wr  = bus_wen && (bus_addr == REG_CTRL);
  assign cmd_wr   = bus_wen && (bus_addr == REG_CMD);
  assign cold_set = ctrl_wr && bus_wdata[CTL_COLD];
  assign clr      = cold_set || cold_q;

  aclk_mainstate u_ms (
    .clk(clk), .rst(rst), .clr(clr),
    .link_on(linkon_q), .xfer_en(xfer_q), .codec_ready(codec_ready_in),
    .state(ms_state), .enter_active(enter_active)
  );

  aclk_cmdslot #(.AW(AW), .DW(DW)) u_slot (
    .clk(clk), .rst(rst), .clr(clr),
    .post(cmd_wr),
    .post_rd(bus_wdata[CMD_RDFLAG]),
    .post_addr(bus_wdata[CMD_ADDR_LSB +: AW]),
    .post_data(bus_wdata[DW-1:0]),
    .ack(slot_ack), .rsp_addr(slot_rsp_addr), .rsp_data(slot_rsp_data),
    .pending(pending), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rep_addr(rep_addr), .rep_data(rep_data), .done(cmd_done)
  );

  // control fields
  always_ff @(posedge clk) begin
    if (rst) begin
      cold_q   <= 1'b0;
      warm_q   <= 1'b0;
      linkon_q <= 1'b0;
      xfer_q   <= 1'b0;
      ie_q     <= 1'b0;
      for (int i = 0; i < NMODE; i++) mode_q[i] <= '0;
    end else if (ctrl_wr) begin
      cold_q   <= bus_wdata[CTL_COLD];
      warm_q   <= !bus_wdata[CTL_COLD] && bus_wdata[CTL_WARM] && (ms_state != MS_ACTIVE);
      linkon_q <= !bus_wdata[CTL_COLD] && bus_wdata[CTL_LINKON];
      xfer_q   <= !bus_wdata[CTL_COLD] && bus_wdata[CTL_XFER];
      ie_q     <= ie_n;
      for (int i = 0; i < NMODE; i++)
        mode_q[i] <= bus_wdata[CTL_COLD] ? '0 : bus_wdata[CTL_MODE0 + i*MW +: MW];
    end
  end

  // ready flag: a ready event wins over a same-cycle clear
  always_comb begin
    if (clr)                          flag_n = 1'b0;
    else if (cmd_done || enter_active) flag_n = 1'b1;
    else if (ctrl_wr && bus_wdata[CTL_IRQCLR]) flag_n = 1'b0;
    else                              flag_n = flag_q;
    if (cold_set)     ie_n = 1'b0;
    else if (ctrl_wr) ie_n = bus_wdata[CTL_RDYIE];
    else              ie_n = ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      irq_q  <= flag_n && ie_n;
    end
  end

  // read path
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      REG_CTRL: begin
        rd_mux[CTL_COLD]   = cold_q;
        rd_mux[CTL_WARM]   = warm_q;
        rd_mux[CTL_LINKON] = linkon_q;
        rd_mux[CTL_XFER]   = xfer_q;
        rd_mux[CTL_RDYIE]  = ie_q;
        for (int i = 0; i < NMODE; i++) rd_mux[CTL_MODE0 + i*MW +: MW] = mode_q[i];
      end
      REG_STAT: begin
        rd_mux[2:0]      = ms_state;
        rd_mux[STS_RDY]  = flag_q;
        rd_mux[STS_BUSY] = pending;
      end
      REG_CMD: begin
        rd_mux[DW-1:0]              = cmd_data;
        rd_mux[CMD_ADDR_LSB +: AW]  = cmd_addr;
        rd_mux[CMD_RDFLAG]          = cmd_rd;
      end
      default: begin
        rd_mux[DW-1:0]             = rep_data;
        rd_mux[CMD_ADDR_LSB +: AW] = rep_addr;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assign lnk_cold     = cold_q;
  assign lnk_warm     = warm_q;
  assign lnk_run      = linkon_q;
  assign lnk_xfer     = xfer_q;
  assign slot_req     = pending;
  assign slot_rd      = cmd_rd;
  assign slot_addr    = cmd_addr;
  assign slot_wdata   = cmd_data;
  assign pcm_in_mode  = mode_q[0];
  assign pcm_out_mode = mode_q[1];
  assign mic_mode     = mode_q[2];
  assign irq          = irq_q;
endmodule

// File: rtl/aclink_ctrl_core_chk.sv
module aclink_ctrl_core_chk #(
  parameter int AW = 7,
  parameter int DW = 16,
  parameter int BW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wen,
  input logic [1:0]    bus_addr,
  input logic [BW-1:0] bus_wdata,
  input logic          slot_req,
  input logic          slot_ack,
  input logic          slot_rd,
  input logic [AW-1:0] slot_addr,
  input logic [DW-1:0] slot_wdata,
  input logic          irq,
  input logic          lnk_cold,
  input logic          lnk_warm,
  input logic [2:0]    state,
  input logic          flag
);
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (slot_req && !slot_ack && !(bus_wen && bus_addr == 2'd0 && bus_wdata[0]))
    |=> (slot_req && $stable(slot_addr) && $stable(slot_wdata) && $stable(slot_rd))); // R4

  AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (rst)
    (slot_req && slot_ack) |=> !slot_req); // R5

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag); // R6

  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (rst)
    state <= 3'd3); // R2

  AST_ACTIVE_FROM_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(state == 3'd3) |-> ($past(state) == 3'd2)); // R2

  AST_COLD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    lnk_cold |-> (state == 3'd0 && !slot_req && !irq)); // R9

  AST_WARM_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd3 && bus_wen && bus_addr == 2'd0) |=> !lnk_warm); // R10
endmodule

bind aclink_ctrl_core aclink_ctrl_core_chk #(.AW(AW), .DW(DW), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .slot_req(slot_req), .slot_ack(slot_ack), .slot_rd(slot_rd), .slot_addr(slot_addr),
  .slot_wdata(slot_wdata), .irq(irq), .lnk_cold(lnk_cold), .lnk_warm(lnk_warm),
  .state(ms_state), .flag(flag_q)
);

// File: tb/aclink_ctrl_core_test.sv
module aclink_ctrl_core_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wen = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic lnk_cold, lnk_warm, lnk_run, lnk_xfer;
  logic codec_ready_in = 1'b0;
  logic slot_req, slot_rd;
  logic [6:0] slot_addr;
  logic [15:0] slot_wdata;
  logic slot_ack = 1'b0;
  logic [6:0] slot_rsp_addr = '0;
  logic [15:0] slot_rsp_data = '0;
  logic [1:0] pcm_in_mode, pcm_out_mode, mic_mode;
  logic irq;

  int nvec = 0;
  int nbad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  aclink_ctrl_core uut (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .lnk_cold(lnk_cold), .lnk_warm(lnk_warm), .lnk_run(lnk_run),
    .lnk_xfer(lnk_xfer), .codec_ready_in(codec_ready_in), .slot_req(slot_req),
    .slot_rd(slot_rd), .slot_addr(slot_addr), .slot_wdata(slot_wdata), .slot_ack(slot_ack),
    .slot_rsp_addr(slot_rsp_addr), .slot_rsp_data(slot_rsp_data),
    .pcm_in_mode(pcm_in_mode), .pcm_out_mode(pcm_out_mode), .mic_mode(mic_mode), .irq(irq)
  );

  localparam logic [31:0] BASE = 32'h1C;   // link-on, transfer enable, ready IE
  localparam logic [31:0] CLR  = 32'h4000_0000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic ack(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    slot_ack = 1'b1; slot_rsp_addr = a; slot_rsp_data = d;
    @(negedge clk);
    slot_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int r = 0; r < 4; r++) begin
      rd(r[1:0], v);
      check("R1 register reads zero", v, 32'h0);
    end
    check("R1 outputs idle", {31'b0, irq | slot_req | lnk_cold | lnk_warm | lnk_run | lnk_xfer}, 32'h0);

    // R11 mode field sweep
    for (int m = 0; m < 64; m++) begin
      wr(2'd0, 32'(m) << 8);
      check("R11 mode pins", {26'b0, mic_mode, pcm_out_mode, pcm_in_mode}, 32'(m));
      rd(2'd0, v);
      check("R11 readback R12", v, 32'(m) << 8);
    end
    wr(2'd0, 32'h0);

    // R2 bring-up order
    wr(2'd0, 32'h4);
    rd(2'd1, v);
    check("R2 state init", v, 32'h1);
    wr(2'd0, 32'hC);
    rd(2'd1, v);
    check("R2 state ready", v, 32'h2);
    wr(2'd0, BASE);
    rd(2'd1, v);
    check("R2 state still ready", v, 32'h2);
    @(negedge clk); codec_ready_in = 1'b1;
    @(negedge clk); codec_ready_in = 1'b0;
    check("R8 R6 irq on active", {31'b0, irq}, 32'h1);
    rd(2'd1, v);
    check("R2 R8 active with flag", v, 32'h13);
    wr(2'd0, BASE | CLR);
    check("R7 irq cleared", {31'b0, irq}, 32'h0);
    rd(2'd1, v);
    check("R7 flag cleared", v, 32'h3);
    rd(2'd0, v);
    check("R7 clear bit reads 0", v, BASE);

    // R10 warm ignored while active
    wr(2'd0, BASE | 32'h2);
    check("R10 warm blocked", {31'b0, lnk_warm}, 32'h0);

    // R3 R5 R6 command sweep over all codec addresses
    for (int a = 0; a < 128; a++) begin
      logic [15:0] d;
      logic rdf;
      d = 16'(a * 613) ^ 16'h5A0F;
      rdf = a[0];
      wr(2'd2, {8'b0, rdf, 7'(a), d});
      check("R3 slot fields", {7'b0, slot_req, slot_rd, slot_addr, slot_wdata}, {7'b0, 1'b1, rdf, 7'(a), d});
      rd(2'd1, v);
      check("R3 busy status", v, 32'h23);
      ack(7'(a), ~d);
      check("R5 R6 retired irq", {30'b0, slot_req, irq}, 32'h1);
      rd(2'd3, v);
      check("R5 reply register", v, {9'b0, 7'(a), ~d});
      rd(2'd1, v);
      check("R5 ready flag", v, 32'h13);
      wr(2'd0, BASE | CLR);
      check("R7 irq cleared", {31'b0, irq}, 32'h0);
    end

    // R4 second command ignored while pending
    wr(2'd2, {8'b0, 1'b0, 7'd5, 16'h1234});
    wr(2'd2, {8'b0, 1'b1, 7'd9, 16'hBEEF});
    check("R4 slot keeps first", {7'b0, slot_rd, slot_addr, slot_wdata}, {7'b0, 1'b0, 7'd5, 16'h1234});
    rd(2'd2, v);
    check("R4 command register keeps first", v, {8'b0, 1'b0, 7'd5, 16'h1234});

    // R7 ready event wins over same-cycle clear
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = 2'd0; bus_wdata = BASE | CLR;
    slot_ack = 1'b1; slot_rsp_addr = 7'd5; slot_rsp_data = 16'h0F0F;
    @(negedge clk);
    bus_wen = 1'b0; slot_ack = 1'b0;
    check("R7 set wins irq", {31'b0, irq}, 32'h1);
    rd(2'd1, v);
    check("R7 set wins flag", v, 32'h13);
    wr(2'd0, BASE | CLR);

    // R9 cold reset with a pending command
    wr(2'd2, {8'b0, 1'b1, 7'd33, 16'h0});
    check("R9 pending before cold", {31'b0, slot_req}, 32'h1);
    wr(2'd0, BASE | 32'h1 | (32'h3F << 8));
    check("R9 cold outputs", {24'b0, lnk_cold, lnk_run, lnk_xfer, slot_req, irq, pcm_in_mode == 2'b0, pcm_out_mode == 2'b0, mic_mode == 2'b0},
          {24'b0, 8'b1000_0111});
    rd(2'd1, v);
    check("R9 state cleared", v, 32'h0);
    rd(2'd3, v);
    check("R9 reply cleared", v, 32'h0);
    rd(2'd0, v);
    check("R9 control holds only cold", v, 32'h1);
    wr(2'd2, {8'b0, 1'b0, 7'd7, 16'hAAAA});
    check("R9 command ignored while held", {31'b0, slot_req}, 32'h1 ^ 32'h1);
    wr(2'd0, 32'h0);
    check("R9 released", {31'b0, lnk_cold}, 32'h0);
    wr(2'd0, 32'h4);
    rd(2'd1, v);
    check("R9 R2 restart init", v, 32'h1);

    // R10 warm reaches pin when not active
    wr(2'd0, 32'h6);
    check("R10 warm driven", {31'b0, lnk_warm}, 32'h1);
    wr(2'd0, 32'h0);
    check("R10 warm released", {31'b0, lnk_warm}, 32'h0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule